// File: doc/BRIEF.md
# MAC Address Table Command Engine

This block holds a small forwarding table of MAC entries. Each entry carries a 48-bit MAC address, a 6-bit database number, a 4-bit entry state, a trunk flag and a port vector. A host reaches the table only through five 16-bit registers. It first writes the MAC, the entry data word and an operation word. The operation word carries a start bit, and the engine then walks the whole table, one slot per clock.

Four kinds of command exist: load or purge one entry, look up the next entry in ascending MAC order within one database, flush entries, and move entries from one port to another. The state field of the data word decides what a flush-type command does. State 0 flushes, state 0xF moves, and state 0xE marks an entry static. The host polls the busy bit, and it issues a new command only after busy has returned to 0.

Top module: `mat_cmd_engine`

## Requirements
- R1: After reset every register reads 0 and the table holds no valid entry.
- R2: Register addresses are: 0 operation, 1 entry data, 2 MAC bytes 0-1, 3 MAC bytes 2-3, 4 MAC bytes 4-5. In each MAC register the lower-numbered byte sits in bits 15:8. Byte 0 is the most significant byte when MACs are ordered.
- R3: Writing address 0 with bit 15 set while idle starts a command. Bit 15 then reads 1 for exactly DEPTH+1 cycles after the write edge and then reads 0. The operation register reads back the opcode in bits 14:12 and the database number in bits 9:8 and 3:0.
- R4: Opcode 3 (load) with a nonzero state in data bits 3:0 stores the entry for (MAC, database), overwriting a match or else taking a free slot. The entry takes its port vector from data bits 11:4 and its trunk flag from data bit 15.
- R5: Opcode 3 with state 0 removes the entry matching (MAC, database).
- R6: Opcode 4 (get-next) returns the valid entry of the selected database with the smallest MAC above the MAC registers. A start MAC of all-ones means start from the lowest MAC. The entry's MAC goes into the MAC registers, and its data word goes to address 1 as {trunk, 000, vector, state}.
- R7: When get-next finds no entry, it leaves data 0 and MAC all-ones.
- R8: Data state 0 with a flush opcode removes entries. Opcode 1 covers all entries in all databases, 2 covers non-static entries in all databases, 5 covers all entries in one database, and 6 covers non-static entries in one database. An entry is static when its state is 0xE.
- R9: Data state 0xF with a flush opcode moves entries within the same scope rules. The from-port is vector bits 3:0 and the to-port is vector bits 7:4. Every in-scope entry that has the from-port bit set has that bit replaced by the to-port bit.
- R10: During a move, a to-port field of 0xF removes every in-scope entry that has the from-port bit set.
- R11: While busy reads 1, host writes to any register are ignored.
- R12: The 6-bit database number splits across the operation word, with bits 5:4 in bits 9:8 and bits 3:0 in bits 3:0. Entries in different databases never interact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Register read data for host_addr (combinational) |

## Verification
A slot written wrongly stays hidden until a later get-next walks past it. The damage then appears as a skipped, duplicated or altered data word, in the MAC and data registers at the end of that command, DEPTH+1 cycles after the start. A wrong scan index or phase shows up sooner, as a busy window of the wrong length, or as operation or data registers that change while busy. The bench therefore follows every table change with get-next walks that expose the whole ordered contents of the affected databases.

// File: rtl/mat_pkg.sv
package mat_pkg;
    localparam int MAC_W = 48;
    localparam int DB_W  = 6;
    localparam int ST_W  = 4;
    localparam int PV_W  = 8;
    localparam int PN_W  = 4;
    localparam int PI_W  = $clog2(PV_W);

    localparam logic [ST_W-1:0] ST_FREE   = 4'h0;
    localparam logic [ST_W-1:0] ST_STATIC = 4'hE;
    localparam logic [ST_W-1:0] ST_MOVE   = 4'hF;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_FL_ALL    = 3'd1,
        OP_FL_DYN    = 3'd2,
        OP_LOAD      = 3'd3,
        OP_NEXT      = 3'd4,
        OP_FL_ALL_DB = 3'd5,
        OP_FL_DYN_DB = 3'd6,
        OP_RSV       = 3'd7
    } opc_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SCAN = 2'd1,
        PH_FIN  = 2'd2
    } phase_e;

    typedef struct packed {
        logic             vld;
        logic [MAC_W-1:0] mac;
        logic [DB_W-1:0]  db;
        logic [ST_W-1:0]  st;
        logic             trunk;
        logic [PV_W-1:0]  vec;
    } ent_t;
endpackage

// File: rtl/mat_entry_store.sv
module mat_entry_store
    import mat_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ent_t             rd_ent,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  ent_t             wr_ent
);
    ent_t slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                slot_q[g] <= wr_ent;
            end
        end
    end

    assign rd_ent = slot_q[rd_idx];
endmodule

// File: rtl/mat_match.sv
module mat_match
    import mat_pkg::*;
(
    input  ent_t            cur,
    input  opc_e            opc,
    input  logic [DB_W-1:0] db,
    input  logic [ST_W-1:0] cmd_st,
    input  logic [PV_W-1:0] cmd_vec,
    output logic            fm_hit,
    output ent_t            fm_ent
);
    logic            all_db;
    logic            is_fm;
    logic            keep_static;
    logic            eligible;
    logic [PN_W-1:0] from_p;
    logic [PN_W-1:0] to_p;

    always_comb begin
        all_db      = (opc == OP_FL_ALL) || (opc == OP_FL_DYN);
        is_fm       = all_db || (opc == OP_FL_ALL_DB) || (opc == OP_FL_DYN_DB);
        keep_static = (opc == OP_FL_DYN) || (opc == OP_FL_DYN_DB);
        from_p      = cmd_vec[PN_W-1:0];
        to_p        = cmd_vec[2*PN_W-1:PN_W];
        eligible    = cur.vld && is_fm && (all_db || cur.db == db)
                      && !(keep_static && cur.st == ST_STATIC);
        fm_hit = 1'b0;
        fm_ent = cur;
        if (eligible) begin
            if (cmd_st == ST_FREE) begin
                fm_hit = 1'b1;
                fm_ent = '0;
            end else if (cmd_st == ST_MOVE) begin
                if (from_p < PN_W'(PV_W) && cur.vec[from_p[PI_W-1:0]]) begin
                    fm_hit = 1'b1;
                    if (to_p == '1) begin
                        fm_ent = '0;
                    end else begin
                        fm_ent.vec[from_p[PI_W-1:0]] = 1'b0;
                        if (to_p < PN_W'(PV_W)) begin
                            fm_ent.vec[to_p[PI_W-1:0]] = 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mat_cmd_engine.sv
module mat_cmd_engine
    import mat_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [2:0]  host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata
);
    typedef struct packed {
        phase_e           ph;
        logic [IDX_W-1:0] idx;
        opc_e             opc;
        logic [DB_W-1:0]  db;
        logic [15:0]      data;
        logic [MAC_W-1:0] mac;
        logic             hit_f;
        logic [IDX_W-1:0] hit_i;
        logic             free_f;
        logic [IDX_W-1:0] free_i;
        logic             nxt_f;
        ent_t             nxt;
    } eng_t;

    eng_t             q, d;
    ent_t             cur;
    ent_t             fm_ent;
    ent_t             ld_ent;
    logic             fm_hit;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    ent_t             wr_ent;
    logic             busy;
    logic             key_hit;
    logic             nxt_better;

    mat_entry_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (q.idx),
        .rd_ent (cur),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_ent (wr_ent)
    );

    mat_match u_match (
        .cur     (cur),
        .opc     (q.opc),
        .db      (q.db),
        .cmd_st  (q.data[ST_W-1:0]),
        .cmd_vec (q.data[PV_W+3:4]),
        .fm_hit  (fm_hit),
        .fm_ent  (fm_ent)
    );

    assign busy = (q.ph != PH_IDLE);

    always_comb begin
        d      = q;
        wr_en  = 1'b0;
        wr_idx = q.idx;
        wr_ent = fm_ent;
        ld_ent = '{vld: 1'b1, mac: q.mac, db: q.db, st: q.data[ST_W-1:0],
                   trunk: q.data[15], vec: q.data[PV_W+3:4]};
        key_hit    = cur.vld && cur.mac == q.mac && cur.db == q.db;
        nxt_better = cur.vld && cur.db == q.db
                     && ((&q.mac) || cur.mac > q.mac)
                     && (!q.nxt_f || cur.mac < q.nxt.mac);
        unique case (q.ph)
            PH_IDLE: begin
                if (host_wr) begin
                    unique case (host_addr)
                        3'd0: begin
                            d.opc = opc_e'(host_wdata[14:12]);
                            d.db  = {host_wdata[9:8], host_wdata[3:0]};
                            if (host_wdata[15]) begin
                                d.ph     = PH_SCAN;
                                d.idx    = '0;
                                d.hit_f  = 1'b0;
                                d.free_f = 1'b0;
                                d.nxt_f  = 1'b0;
                            end
                        end
                        3'd1: d.data        = host_wdata;
                        3'd2: d.mac[47:32]  = host_wdata;
                        3'd3: d.mac[31:16]  = host_wdata;
                        3'd4: d.mac[15:0]   = host_wdata;
                        default: ;
                    endcase
                end
            end
            PH_SCAN: begin
                if (q.opc == OP_LOAD) begin
                    if (key_hit && !q.hit_f) begin
                        d.hit_f = 1'b1;
                        d.hit_i = q.idx;
                    end
                    if (!cur.vld && !q.free_f) begin
                        d.free_f = 1'b1;
                        d.free_i = q.idx;
                    end
                end
                if (q.opc == OP_NEXT && nxt_better) begin
                    d.nxt_f = 1'b1;
                    d.nxt   = cur;
                end
                if (fm_hit) begin
                    wr_en  = 1'b1;
                    wr_ent = fm_ent;
                end
                if (q.idx == IDX_W'(DEPTH - 1)) begin
                    d.ph = PH_FIN;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            PH_FIN: begin
                d.ph = PH_IDLE;
                if (q.opc == OP_LOAD) begin
                    if (q.data[ST_W-1:0] == ST_FREE) begin
                        wr_en  = q.hit_f;
                        wr_idx = q.hit_i;
                        wr_ent = '0;
                    end else begin
                        wr_en  = q.hit_f || q.free_f;
                        wr_idx = q.hit_f ? q.hit_i : q.free_i;
                        wr_ent = ld_ent;
                    end
                end
                if (q.opc == OP_NEXT) begin
                    if (q.nxt_f) begin
                        d.mac  = q.nxt.mac;
                        d.data = {q.nxt.trunk, 3'b000, q.nxt.vec, q.nxt.st};
                    end else begin
                        d.mac  = '1;
                        d.data = '0;
                    end
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (host_addr)
            3'd0:    host_rdata = {busy, q.opc, 2'b00, q.db[5:4], 4'b0000, q.db[3:0]};
            3'd1:    host_rdata = q.data;
            3'd2:    host_rdata = q.mac[47:32];
            3'd3:    host_rdata = q.mac[31:16];
            3'd4:    host_rdata = q.mac[15:0];
            default: host_rdata = '0;
        endcase
    end

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_wr && host_addr == 3'd0 && host_wdata[15]) |=> busy);

    // R3
    fin_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_FIN) |=> !busy);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr) |=> ($stable(q.opc) && $stable(q.db)));

    // R6
    scan_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_SCAN && (q.opc == OP_LOAD || q.opc == OP_NEXT)) |-> !wr_en);

    // R7
    next_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_FIN && q.opc == OP_NEXT) |=> (q.data[3:0] != 4'h0 || (&q.mac)));
endmodule

// File: tb/mat_cmd_engine_tb_top.sv
module mat_cmd_engine_tb_top;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic        mon_stb = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    mat_cmd_engine #(.DEPTH(DEPTH)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    task automatic compare(input logic [15:0] got, input logic [15:0] exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mon_stb && exp_q.size() > 0) begin
            compare(host_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic hw(input logic [2:0] a, input logic [15:0] v);
        host_wr = 1'b1; host_addr = a; host_wdata = v;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic chk(input logic [2:0] a, input logic [15:0] v, input string tag);
        host_addr = a;
        exp_q.push_back(v);
        tag_q.push_back(tag);
        mon_stb = 1'b1;
        @(posedge clk); #1;
        mon_stb = 1'b0;
    endtask

    task automatic wait_idle(output int cnt);
        cnt = 0;
        host_addr = 3'd0;
        @(negedge clk);
        while (host_rdata[15] && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        @(posedge clk); #1;
    endtask

    task automatic run_op(input logic [15:0] w);
        int c;
        hw(3'd0, w | 16'h8000);
        wait_idle(c);
    endtask

    task automatic setmac(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
        hw(3'd2, a); hw(3'd3, b); hw(3'd4, c);
    endtask

    task automatic chk_entry(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
                             input logic [15:0] dv, input string tag);
        chk(3'd2, a, tag); chk(3'd3, b, tag); chk(3'd4, c, tag); chk(3'd1, dv, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        for (int i = 0; i < 5; i++) chk(3'(i), 16'h0000, "R1 reset register");
        // R2 R3 R4 load A with busy window
        setmac(16'h0011, 16'h2233, 16'h4455);
        hw(3'd1, 16'h0057);
        hw(3'd0, 16'hB003);
        wait_idle(cnt);
        compare(16'(cnt), 16'(DEPTH + 1), "R3 busy cycles");
        chk(3'd0, 16'h3003, "R3 op readback");
        chk(3'd2, 16'h0011, "R2 mac register readback");
        // load B (static, port3), C, D (db 0x25, trunk)
        setmac(16'h0011, 16'h2233, 16'h4410); hw(3'd1, 16'h008E); run_op(16'h3003);
        setmac(16'hAA00, 16'h0000, 16'h0001); hw(3'd1, 16'h0017); run_op(16'h3003);
        setmac(16'h0000, 16'h0000, 16'h0009); hw(3'd1, 16'h8047); run_op(16'h3205);
        // R6 ascending walk db3
        setmac(16'hFFFF, 16'hFFFF, 16'hFFFF); run_op(16'h4003);
        chk_entry(16'h0011, 16'h2233, 16'h4410, 16'h008E, "R6 first entry");
        run_op(16'h4003);
        chk_entry(16'h0011, 16'h2233, 16'h4455, 16'h0057, "R6 second entry");
        run_op(16'h4003);
        chk_entry(16'hAA00, 16'h0000, 16'h0001, 16'h0017, "R6 third entry");
        run_op(16'h4003);
        chk_entry(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0000, "R7 end of walk");
        chk(3'd0, 16'h4003, "R3 op readback get-next");
        // R12 database split
        setmac(16'hFFFF, 16'hFFFF, 16'hFFFF); run_op(16'h4205);
        chk_entry(16'h0000, 16'h0000, 16'h0009, 16'h8047, "R12 db 0x25 entry with trunk R4");
        setmac(16'hFFFF, 16'hFFFF, 16'hFFFF); run_op(16'h4005);
        chk(3'd1, 16'h0000, "R12 db 0x05 empty");
        // R4 overwrite A
        setmac(16'h0011, 16'h2233, 16'h4455); hw(3'd1, 16'h0087); run_op(16'h3003);
        setmac(16'h0011, 16'h2233, 16'h4410); run_op(16'h4003);
        chk_entry(16'h0011, 16'h2233, 16'h4455, 16'h0087, "R4 overwritten entry");
        run_op(16'h4003);
        chk(3'd2, 16'hAA00, "R4 no duplicate after overwrite");
        // R5 purge C
        setmac(16'hAA00, 16'h0000, 16'h0001); hw(3'd1, 16'h0000); run_op(16'h3003);
        setmac(16'h0011, 16'h2233, 16'h4455); run_op(16'h4003);
        chk(3'd1, 16'h0000, "R5 purged entry gone");
        // R9 move non-static db3 port3 -> port6
        hw(3'd1, 16'h063F); run_op(16'h6003);
        setmac(16'hFFFF, 16'hFFFF, 16'hFFFF); run_op(16'h4003);
        chk(3'd1, 16'h008E, "R9 static entry untouched by non-static move");
        run_op(16'h4003);
        chk(3'd1, 16'h0407, "R9 moved entry");
        // R10 move to all-ones removes
        hw(3'd1, 16'h0F3F); run_op(16'h5003);
        setmac(16'hFFFF, 16'hFFFF, 16'hFFFF); run_op(16'h4003);
        chk(3'd1, 16'h0407, "R10 entry off from-port kept");
        run_op(16'h4003);
        chk(3'd1, 16'h0000, "R10 entry on from-port removed");
        setmac(16'hFFFF, 16'hFFFF, 16'hFFFF); run_op(16'h4205);
        chk(3'd1, 16'h8047, "R9 other database out of scope");
        // R8 non-static flush all databases
        setmac(16'h0000, 16'h0000, 16'h0005); hw(3'd1, 16'h001E); run_op(16'h3205);
        hw(3'd1, 16'h0000); run_op(16'h2000);
        setmac(16'hFFFF, 16'hFFFF, 16'hFFFF); run_op(16'h4205);
        chk_entry(16'h0000, 16'h0000, 16'h0005, 16'h001E, "R8 static entry kept");
        run_op(16'h4205);
        chk(3'd1, 16'h0000, "R8 dynamic entry flushed");
        setmac(16'hFFFF, 16'hFFFF, 16'hFFFF); run_op(16'h4003);
        chk(3'd1, 16'h0000, "R8 flush reached db3");
        // R8 flush all
        hw(3'd1, 16'h0000); run_op(16'h1000);
        setmac(16'hFFFF, 16'hFFFF, 16'hFFFF); run_op(16'h4205);
        chk(3'd1, 16'h0000, "R8 full flush removes static");
        // R11 writes during busy ignored
        setmac(16'h0011, 16'h2233, 16'h4455); hw(3'd1, 16'h0017);
        hw(3'd0, 16'hB003);
        hw(3'd1, 16'h0000);
        hw(3'd0, 16'hD003);
        hw(3'd2, 16'h1234);
        wait_idle(cnt);
        chk(3'd0, 16'h3003, "R11 op register kept");
        chk(3'd1, 16'h0017, "R11 data register kept");
        chk(3'd2, 16'h0011, "R11 mac register kept");
        setmac(16'hFFFF, 16'hFFFF, 16'hFFFF); run_op(16'h4003);
        chk_entry(16'h0011, 16'h2233, 16'h4455, 16'h0017, "R11 ignored flush, load kept");
        repeat (2) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule